// File: doc/BRIEF.md
# Long-Mode Interrupt Gate Validator

This block decides whether an interrupt may be delivered through a 16-byte long-mode interrupt table entry, or whether the delivery must fault. The caller supplies three things in the same cycle as a one-cycle launch strobe: the fetched entry, the vector number, and the 8-byte descriptor of the code segment that the gate selects. One cycle later the block presents its verdict with a `done` pulse, along with the assembled 64-bit handler address.

The block runs three checks in a fixed order and reports only the first one that fails. First it checks the gate type. The two 64-bit gate types pass, the 16-bit gate types fault with a zero error code, and every other type faults with an error code that cites the vector. Next it checks the target code segment, which must be marked as 64-bit (long bit set, default-size bit clear). Last it checks that the handler address is in canonical form for the configured virtual-address width. Every fault is a general-protection fault.

Top module: `igv_top`

## Requirements
- R1: A launch (`checkValid` high at a rising clock edge) produces a result at that edge, and `done` is high for exactly the following cycle. `done` is low in every cycle that does not follow a launch.
- R2: While `rstN` is low and after it is released, before any launch, `done`, `fault`, `faultClass`, `errCode` and `targetIp` are all zero.
- R3: A gate type field (entry bits 43:40) of 4'hE (64-bit interrupt gate) or 4'hF (64-bit trap gate) passes the gate-type check.
- R4: A gate type of 4'h6 or 4'h7 (16-bit gates) faults with `faultClass` = 2'b01 (general protection) and `errCode` = 0.
- R5: Any other gate type faults with `faultClass` = 2'b01 and `errCode` = {vector, 3'b010}, which is vector×8 with bit 1 set to mark an interrupt-table reference.
- R6: When the gate type passes, a code segment descriptor that does not have L (bit 53) = 1 and D (bit 54) = 0 faults with `faultClass` = 2'b01 and `errCode` = {vector, 3'b010}.
- R7: When the gate type and the code segment both pass, a handler address whose bits 63 down to VA_WIDTH-1 are not all equal faults with `faultClass` = 2'b01 and `errCode` = 0. VA_WIDTH defaults to 48.
- R8: When more than one check fails, the result is the one from the earliest check in the order gate type, code segment, canonical address.
- R9: `targetIp` is assembled as {entry[95:64], entry[63:48], entry[15:0]} on every launch, whether or not the launch faults.
- R10: When all checks pass, `fault` = 0, `faultClass` = 2'b00 and `errCode` = 0.
- R11: Between launches the result outputs hold their values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| checkValid | input | 1 | One-cycle launch strobe |
| gateEntry | input | 128 | Fetched 16-byte interrupt table entry |
| vector | input | 8 | Interrupt vector number |
| csDesc | input | 64 | Descriptor of the target code segment |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Delivery must fault |
| faultClass | output | 2 | 00 none, 01 general protection |
| errCode | output | 16 | Fault error code |
| targetIp | output | 64 | Assembled handler address |

## Verification
The bench sweeps every gate type against every L/D pairing and against handler addresses on both sides of the canonical boundary. This exposes a design that swaps the 16-bit and 64-bit type codes, or that accepts L=1 with D=1. It also exposes a canonical check that is off by one bit, which would accept 0x0000_8000_0000_0000 or reject 0xFFFF_8000_0000_0000. Cases where several checks fail at once catch a design that reports a later check instead of the earlier one; such a design would give a zero error code where the vector should be cited, or the reverse. Hold cycles with changed inputs catch result registers that reload without a launch.

// File: rtl/igv_pkg.sv
package igv_pkg;
  // Fault class encoding presented at the top ports
  localparam logic [1:0] FC_NONE = 2'b00;
  localparam logic [1:0] FC_GP   = 2'b01;

  // Gate type codes (entry bits 43:40)
  localparam logic [3:0] GT_INT64  = 4'hE;
  localparam logic [3:0] GT_TRAP64 = 4'hF;
  localparam logic [3:0] GT_INT16  = 4'h6;
  localparam logic [3:0] GT_TRAP16 = 4'h7;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // load result registers
    logic fault;       // delivery faults
    logic citeVector;  // error code names the vector
  } igvStrobe_t;
endpackage

// File: rtl/igv_datapath.sv
module igv_datapath
  import igv_pkg::*;
#(
  parameter int VA_WIDTH = 48,
  parameter int VEC_W    = 8,
  parameter int ERR_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [127:0]     gateEntry,
  input  logic [VEC_W-1:0] vector,
  input  logic [63:0]      csDesc,
  input  igvStrobe_t       strobe,
  output logic             typeOk,
  output logic             typeLegacy16,
  output logic             csBad,
  output logic             nonCanon,
  output logic             fault,
  output logic [1:0]       faultClass,
  output logic [ERR_W-1:0] errCode,
  output logic [63:0]      targetIp
);
  localparam int TOP_BITS = 64 - VA_WIDTH + 1;
  localparam int PAD_W    = ERR_W - VEC_W - 3;

  logic [3:0]          gateType;
  logic [63:0]         ipNext;
  logic [TOP_BITS-1:0] ipTop;
  logic [ERR_W-1:0]    vecCode;

  assign gateType     = gateEntry[43:40];
  assign ipNext       = {gateEntry[95:64], gateEntry[63:48], gateEntry[15:0]};
  assign ipTop        = ipNext[63:VA_WIDTH-1];
  assign typeOk       = (gateType == GT_INT64) || (gateType == GT_TRAP64);
  assign typeLegacy16 = (gateType == GT_INT16) || (gateType == GT_TRAP16);
  assign csBad        = !(csDesc[53] && !csDesc[54]);
  assign nonCanon     = !((&ipTop) || !(|ipTop));

  generate
    if (PAD_W > 0) begin : g_pad
      assign vecCode = {{PAD_W{1'b0}}, vector, 3'b010};
    end else begin : g_nopad
      assign vecCode = ERR_W'({vector, 3'b010});
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fault      <= 1'b0;
      faultClass <= FC_NONE;
      errCode    <= '0;
      targetIp   <= '0;
    end else if (strobe.capture) begin
      fault      <= strobe.fault;
      faultClass <= strobe.fault ? FC_GP : FC_NONE;
      errCode    <= strobe.citeVector ? vecCode : '0;
      targetIp   <= ipNext;
    end
  end
endmodule

// File: rtl/igv_control.sv
module igv_control
  import igv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       checkValid,
  input  logic       typeOk,
  input  logic       typeLegacy16,
  input  logic       csBad,
  input  logic       nonCanon,
  output igvStrobe_t strobe,
  output logic       done
);
  always_comb begin
    strobe.capture    = checkValid;
    strobe.fault      = 1'b0;
    strobe.citeVector = 1'b0;
    if (!typeOk) begin
      strobe.fault      = 1'b1;
      strobe.citeVector = !typeLegacy16;
    end else if (csBad) begin
      strobe.fault      = 1'b1;
      strobe.citeVector = 1'b1;
    end else if (nonCanon) begin
      strobe.fault      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= checkValid;
  end
endmodule

// File: rtl/igv_top.sv
module igv_top
  import igv_pkg::*;
#(
  parameter int VA_WIDTH = 48
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         checkValid,
  input  logic [127:0] gateEntry,
  input  logic [7:0]   vector,
  input  logic [63:0]  csDesc,
  output logic         done,
  output logic         fault,
  output logic [1:0]   faultClass,
  output logic [15:0]  errCode,
  output logic [63:0]  targetIp
);
  igvStrobe_t strobe;
  logic typeOk, typeLegacy16, csBad, nonCanon;

  igv_control u_ctl (
    .clk(clk), .rstN(rstN), .checkValid(checkValid),
    .typeOk(typeOk), .typeLegacy16(typeLegacy16),
    .csBad(csBad), .nonCanon(nonCanon),
    .strobe(strobe), .done(done)
  );

  igv_datapath #(.VA_WIDTH(VA_WIDTH), .VEC_W(8), .ERR_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .gateEntry(gateEntry), .vector(vector),
    .csDesc(csDesc), .strobe(strobe),
    .typeOk(typeOk), .typeLegacy16(typeLegacy16),
    .csBad(csBad), .nonCanon(nonCanon),
    .fault(fault), .faultClass(faultClass),
    .errCode(errCode), .targetIp(targetIp)
  );
endmodule

// File: rtl/igv_checker.sv
module igv_checker (
  input logic        clk,
  input logic        rstN,
  input logic        checkValid,
  input logic        done,
  input logic        fault,
  input logic [1:0]  faultClass,
  input logic [15:0] errCode,
  input logic [63:0] targetIp
);
  a_r1_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    checkValid |=> done);
  a_r1_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |=> !done);
  a_r4_class_matches: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (fault == (faultClass == 2'b01)) && (faultClass != 2'b10) && (faultClass != 2'b11));
  a_r10_pass_no_code: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault) |-> (errCode == 16'h0));
  a_r5_code_shape: assert property (@(posedge clk) disable iff (!rstN)
    (done && errCode != 16'h0) |-> (errCode[2:0] == 3'b010) && fault);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |=> $stable(targetIp) && $stable(errCode) && $stable(fault));
endmodule

bind igv_top igv_checker u_igvChk (
  .clk(clk), .rstN(rstN), .checkValid(checkValid), .done(done),
  .fault(fault), .faultClass(faultClass), .errCode(errCode),
  .targetIp(targetIp)
);

// File: tb/sim_igv_top.sv
module sim_igv_top;
  localparam int CLK_PERIOD = 10;
  localparam int VA = 48;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         checkValid = 1'b0;
  logic [127:0] gateEntry = '0;
  logic [7:0]   vector = '0;
  logic [63:0]  csDesc = '0;
  logic         done, fault;
  logic [1:0]   faultClass;
  logic [15:0]  errCode;
  logic [63:0]  targetIp;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  igv_top #(.VA_WIDTH(VA)) u0 (
    .clk(clk), .rstN(rstN), .checkValid(checkValid), .gateEntry(gateEntry),
    .vector(vector), .csDesc(csDesc), .done(done), .fault(fault),
    .faultClass(faultClass), .errCode(errCode), .targetIp(targetIp)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mkEntry(input logic [3:0] t, input logic [63:0] ip);
    logic [127:0] e;
    e = 128'hA5A5_0000_0000_0000_0000_0000_0000_0000;
    e[15:0]  = ip[15:0];
    e[31:16] = 16'h0010;
    e[43:40] = t;
    e[47]    = 1'b1;
    e[63:48] = ip[31:16];
    e[95:64] = ip[63:32];
    return e;
  endfunction

  function automatic bit isCanon(input logic [63:0] ip);
    logic [63:0] top;
    top = ip >> (VA - 1);
    return (top == 64'd0) || (top == ((64'd1 << (64 - VA + 1)) - 1));
  endfunction

  task automatic launch(input logic [3:0] t, input logic [1:0] ld,
                        input logic [63:0] ip, input logic [7:0] v);
    gateEntry  = mkEntry(t, ip);
    vector     = v;
    csDesc     = 64'h00AF_9A00_0000_FFFF;
    csDesc[53] = ld[1];
    csDesc[54] = ld[0];
    checkValid = 1'b1;
    @(negedge clk);
    checkValid = 1'b0;
  endtask

  logic [63:0] ips [6];

  initial begin
    ips[0] = 64'h0000_7FFF_FFFF_F000;
    ips[1] = 64'hFFFF_8000_0000_1234;
    ips[2] = 64'h0000_8000_0000_0000;
    ips[3] = 64'h8000_0000_0000_0000;
    ips[4] = 64'h0000_0000_0000_0000;
    ips[5] = 64'hFFFF_FFFF_FFFF_FFF0;

    @(negedge clk);
    // R2: reset state
    chk("R2", "done", 64'(done), 64'd0);
    chk("R2", "fault", 64'(fault), 64'd0);
    chk("R2", "class", 64'(faultClass), 64'd0);
    chk("R2", "errCode", 64'(errCode), 64'd0);
    chk("R2", "targetIp", targetIp, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2", "done after release", 64'(done), 64'd0);
    chk("R2", "ip after release", targetIp, 64'd0);

    for (int t = 0; t < 16; t++) begin
      for (int ld = 0; ld < 4; ld++) begin
        for (int k = 0; k < 6; k++) begin
          for (int vi = 0; vi < 2; vi++) begin
            logic [7:0] v;
            bit tOk, t16, cOk, cn, expF;
            logic [15:0] expE;
            string req;
            v    = (vi == 0) ? 8'h0D : 8'hFF - 8'(t);
            tOk  = (t == 14) || (t == 15);
            t16  = (t == 6) || (t == 7);
            cOk  = (ld == 2);  // L=1, D=0
            cn   = isCanon(ips[k]);
            expF = 1'b0; expE = 16'h0; req = "R10";
            if (!tOk) begin
              expF = 1'b1; req = t16 ? "R4" : "R5";
              expE = t16 ? 16'h0 : 16'(v) * 16'd8 + 16'd2;
            end else if (!cOk) begin
              expF = 1'b1; req = "R6"; expE = 16'(v) * 16'd8 + 16'd2;
            end else if (!cn) begin
              expF = 1'b1; req = "R7"; expE = 16'h0;
            end else begin
              req = "R3";
            end
            launch(4'(t), 2'(ld), ips[k], v);
            // result registered at the launch edge, sampled one negedge later
            chk("R1", "done", 64'(done), 64'd1);
            chk(req, "fault R8", 64'(fault), 64'(expF));
            chk(req, "class", 64'(faultClass), expF ? 64'd1 : 64'd0);
            chk(req, "errCode R8", 64'(errCode), 64'(expE));
            chk("R9", "targetIp", targetIp, ips[k]);
            if (k == 5 && vi == 1) begin
              // R11: idle cycle with changed inputs must not disturb results
              gateEntry = ~gateEntry;
              vector    = ~vector;
              csDesc    = ~csDesc;
              @(negedge clk);
              chk("R1", "done idle", 64'(done), 64'd0);
              chk("R11", "fault hold", 64'(fault), 64'(expF));
              chk("R11", "err hold", 64'(errCode), 64'(expE));
              chk("R11", "ip hold", targetIp, ips[k]);
            end
          end
        end
      end
    end

    // R1: back-to-back launches each give done
    launch(4'hE, 2'd2, ips[0], 8'h20);
    chk("R1", "b2b first", 64'(done), 64'd1);
    launch(4'h3, 2'd0, ips[2], 8'h21);
    chk("R1", "b2b second", 64'(done), 64'd1);
    chk("R8", "b2b code", 64'(errCode), 64'h10A);
    @(negedge clk);
    chk("R1", "b2b tail", 64'(done), 64'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule